// File: doc/BRIEF.md
# Chip-Erase Command Sequencer

This block is a small bus master that sits between a host controller and a parallel NOR flash. A one-cycle start request makes it emit the six-write unlock/setup/unlock/erase pattern that starts a whole-chip erase. It then waits for the device to report ready, and signals either completion or a timeout. Each write holds address and data for one clock, drives write-enable for a programmable number of clocks, and then holds address and data for one more clock.

The pattern uses two offsets from a base address. A primary offset carries the first unlock code, the setup code and the erase code. A secondary offset carries the second unlock code. Both offsets depend on whether the flash bus runs in byte or word mode. The base address and the mode are captured at start and cannot change until the run ends. Once a run has begun, nothing short of reset stops it.

States: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD`, `ST_WAIT`. Transitions:
- start: `ST_IDLE` to `ST_SETUP`.
- always: `ST_SETUP` to `ST_STROBE`.
- pulse count reached: `ST_STROBE` to `ST_HOLD`.
- more steps: `ST_HOLD` to `ST_SETUP`.
- last step: `ST_HOLD` to `ST_WAIT`.
- ready or limit reached: `ST_WAIT` to `ST_IDLE`.

Top module: `erase_seq_top`

## Requirements
- R1: While reset is active, and after it is released, `bus_we`, `busy`, `done` and `timeout_err` are 0, and `bus_addr` and `bus_data` are 0.
- R2: A run issues exactly six writes with data, in order, 00AAh, 0055h, 0080h, 00AAh, 0055h, 0010h.
- R3: With `byte_mode`=0, the six write addresses are base+555h, base+2AAh, base+555h, base+555h, base+2AAh, base+555h, taken modulo 2^ADDR_W.
- R4: With `byte_mode`=1, the six write addresses are base+AAAh, base+555h, base+AAAh, base+AAAh, base+555h, base+AAAh, taken modulo 2^ADDR_W.
- R5: Each write shows its address and data for exactly one clock with `bus_we`=0, then holds `bus_we`=1 for PULSE_CLKS clocks, then keeps the same address and data for one clock with `bus_we`=0. Write-enable stays low for at least two clocks between writes.
- R6: `start` is acted on only when the block is idle. The first clock edge that samples it captures `base_addr` and `byte_mode`, and `busy` is 1 from that edge until the run ends.
- R7: In `ST_WAIT`, a clock edge that samples `ready`=1 ends the run. On that same edge `done` goes to 1 for exactly one clock and `busy` goes to 0.
- R8: If `ready` stays 0 for TIMEOUT_CLKS clocks in `ST_WAIT`, `timeout_err` goes to 1 for one clock, `busy` falls, and `done` stays 0. This happens TIMEOUT_CLKS edges after the wait begins, which is 6*(PULSE_CLKS+2)+TIMEOUT_CLKS edges after start is sampled.
- R9: A `start` pulse while `busy`=1 is ignored. The running pattern keeps its captured base and mode, and no extra run follows.
- R10: There is no abort input. Only reset ends a run early: it drops `bus_we` and `busy` at once, and no write follows after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a chip-erase run |
| byte_mode | input | 1 | 1 selects byte-bus offsets, 0 selects word-bus offsets |
| base_addr | input | ADDR_W | Flash base address |
| ready | input | 1 | Device ready (1) / busy (0) |
| bus_addr | output | ADDR_W | Flash address |
| bus_data | output | DATA_W | Flash write data |
| bus_we | output | 1 | Write-enable, active high |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse: erase reported complete |
| timeout_err | output | 1 | One-clock pulse: ready never came |

## Verification
The main pattern is tried with both bus modes and with several bases, among them zero and a base whose offsets wrap past the top of the address space. This separates the byte and word offset selection and confirms that the addition wraps modulo the address width. Each run waits a different number of clocks before raising ready, so the one-edge completion latency is measured rather than assumed. Separate runs with ready held low, with a start pulse carrying a different base and mode, and with reset asserted mid-pattern isolate the timeout count, start rejection while busy, and the absence of any abort path.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT
    } seq_state_t;

    typedef enum logic {
        OFF_PRIMARY,
        OFF_SECONDARY
    } off_sel_t;

    localparam int unsigned NUM_STEPS = 6;
    localparam int unsigned STEP_W    = 3;

    localparam logic [15:0] CODE_UNLOCK_A = 16'h00AA;
    localparam logic [15:0] CODE_UNLOCK_B = 16'h0055;
    localparam logic [15:0] CODE_SETUP    = 16'h0080;
    localparam logic [15:0] CODE_ERASE    = 16'h0010;

    localparam logic [11:0] OFF_BYTE_PRI  = 12'hAAA;
    localparam logic [11:0] OFF_BYTE_SEC  = 12'h555;
    localparam logic [11:0] OFF_WORD_PRI  = 12'h555;
    localparam logic [11:0] OFF_WORD_SEC  = 12'h2AA;

endpackage

// File: rtl/erase_step_table.sv
module erase_step_table
    import erase_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 16
) (
    input  logic [STEP_W-1:0] step,
    input  logic              byte_mode,
    output logic [ADDR_W-1:0] offset,
    output logic [DATA_W-1:0] data
);

    off_sel_t    sel;
    logic [15:0] code;
    logic [11:0] off12;

    always_comb begin
        unique case (step)
            3'd0:    begin sel = OFF_PRIMARY;   code = CODE_UNLOCK_A; end
            3'd1:    begin sel = OFF_SECONDARY; code = CODE_UNLOCK_B; end
            3'd2:    begin sel = OFF_PRIMARY;   code = CODE_SETUP;    end
            3'd3:    begin sel = OFF_PRIMARY;   code = CODE_UNLOCK_A; end
            3'd4:    begin sel = OFF_SECONDARY; code = CODE_UNLOCK_B; end
            3'd5:    begin sel = OFF_PRIMARY;   code = CODE_ERASE;    end
            default: begin sel = OFF_PRIMARY;   code = 16'h0000;      end
        endcase
    end

    always_comb begin
        if (byte_mode) off12 = (sel == OFF_PRIMARY) ? OFF_BYTE_PRI : OFF_BYTE_SEC;
        else           off12 = (sel == OFF_PRIMARY) ? OFF_WORD_PRI : OFF_WORD_SEC;
    end

    assign offset = ADDR_W'(off12);

    generate
        if (DATA_W >= 16) begin : g_data_wide
            assign data = DATA_W'(code);
        end else begin : g_data_narrow
            assign data = code[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/erase_seq_counter.sv
module erase_seq_counter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (inc)    count <= count + 1'b1;
    end

endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
    import erase_seq_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned PULSE_CLKS   = 4,
    parameter int unsigned TIMEOUT_CLKS = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_we,
    output logic              busy,
    output logic              done,
    output logic              timeout_err
);

    localparam int unsigned CNT_MAX = (PULSE_CLKS > TIMEOUT_CLKS) ? PULSE_CLKS : TIMEOUT_CLKS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_STEPS - 1);
    localparam logic [CNT_W-1:0]  PULSE_LAST = CNT_W'(PULSE_CLKS - 1);
    localparam logic [CNT_W-1:0]  WAIT_LAST  = CNT_W'(TIMEOUT_CLKS - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] base_q;
    logic              byte_q;
    logic              done_q;
    logic              tmo_q;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clear;
    logic              cnt_inc;
    logic [ADDR_W-1:0] tbl_offset;
    logic [DATA_W-1:0] tbl_data;
    logic              on_bus;

    erase_step_table #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_table (
        .step      (step_q),
        .byte_mode (byte_q),
        .offset    (tbl_offset),
        .data      (tbl_data)
    );

    assign cnt_inc   = (state_q == ST_STROBE) || (state_q == ST_WAIT);
    assign cnt_clear = !cnt_inc;

    erase_seq_counter #(
        .WIDTH (CNT_W)
    ) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (cnt == PULSE_LAST) state_d = ST_HOLD;
            ST_HOLD:   state_d = (step_q == LAST_STEP) ? ST_WAIT : ST_SETUP;
            ST_WAIT:   if (ready || cnt == WAIT_LAST) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured run context and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            base_q <= '0;
            byte_q <= 1'b0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                base_q <= base_addr;
                byte_q <= byte_mode;
                step_q <= '0;
            end else if (state_q == ST_HOLD && step_q != LAST_STEP) begin
                step_q <= step_q + 1'b1;
            end
            done_q <= (state_q == ST_WAIT) && ready;
            tmo_q  <= (state_q == ST_WAIT) && !ready && (cnt == WAIT_LAST);
        end
    end

    // Outputs
    always_comb begin
        on_bus   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        busy     = (state_q != ST_IDLE);
        bus_we   = (state_q == ST_STROBE);
        bus_addr = on_bus ? (base_q + tbl_offset) : '0;
        bus_data = on_bus ? tbl_data : '0;
    end

    assign done        = done_q;
    assign timeout_err = tmo_q;

    // Assertions
    assert_setup_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $stable(bus_addr) && $stable(bus_data));

    assert_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && $past(bus_we)) |-> $stable(bus_addr) && $stable(bus_data));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_we) |-> $stable(bus_addr) && $stable(bus_data));

    assert_we_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> busy);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_q) && $stable(byte_q));

    assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ready) && !timeout_err && !busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_timeout_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !$past(ready) && !busy);

endmodule

// File: tb/test_erase_seq_top.sv
module test_erase_seq_top;

    localparam int unsigned AW = 24;
    localparam int unsigned DW = 16;
    localparam int unsigned P  = 3;
    localparam int unsigned TO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          byte_mode = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          bus_we, busy, done, timeout_err;

    erase_seq_top #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CLKS(P), .TIMEOUT_CLKS(TO)) i_erase_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
        .base_addr(base_addr), .ready(ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_we(bus_we), .busy(busy), .done(done),
        .timeout_err(timeout_err)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus monitor: records every write and its timing
    int            mon_rises = 0;
    int            mon_falls = 0;
    int            mon_bad   = 0;
    logic [AW-1:0] cap_addr [0:63];
    logic [DW-1:0] cap_data [0:63];
    logic          p_we = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    int            hi_len = 0;
    int            lo_len = 2;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_we   = 1'b0;
            hi_len = 0;
            lo_len = 2;
        end else begin
            if (bus_we && !p_we) begin
                cap_addr[mon_rises % 64] = bus_addr;
                cap_data[mon_rises % 64] = bus_data;
                if (bus_addr !== p_addr || bus_data !== p_data || lo_len < 2) mon_bad++;
                mon_rises++;
                hi_len = 1;
            end else if (bus_we && p_we) begin
                if (bus_addr !== p_addr || bus_data !== p_data) mon_bad++;
                hi_len++;
            end else if (!bus_we && p_we) begin
                if (bus_addr !== p_addr || bus_data !== p_data || hi_len != P) mon_bad++;
                mon_falls++;
                lo_len = 1;
            end else begin
                lo_len++;
            end
            p_we   = bus_we;
            p_addr = bus_addr;
            p_data = bus_data;
        end
    end

    function automatic logic [AW-1:0] exp_addr(input int s, input logic bm, input logic [AW-1:0] b);
        logic [AW-1:0] pri, sec;
        pri = bm ? AW'(12'hAAA) : AW'(12'h555);
        sec = bm ? AW'(12'h555) : AW'(12'h2AA);
        return b + ((s == 1 || s == 4) ? sec : pri);
    endfunction

    function automatic logic [DW-1:0] exp_data(input int s);
        case (s)
            0, 3:    return 16'h00AA;
            1, 4:    return 16'h0055;
            2:       return 16'h0080;
            default: return 16'h0010;
        endcase
    endfunction

    // Vector: {byte_mode, base, ready delay}
    typedef struct packed {
        logic          bm;
        logic [AW-1:0] base;
        logic [7:0]    dly;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 24'h000000, 8'd0},
        '{1'b1, 24'h000000, 8'd3},
        '{1'b0, 24'h400000, 8'd7},
        '{1'b1, 24'h123000, 8'd1},
        '{1'b0, 24'hFFFC00, 8'd12}
    };

    task automatic pulse_start(input logic bm, input logic [AW-1:0] b);
        byte_mode = bm;
        base_addr = b;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_falls(input int target);
        while (mon_falls < target) @(negedge clk);
    endtask

    task automatic check_writes(input int r0, input logic bm, input logic [AW-1:0] b);
        for (int s = 0; s < 6; s++) begin
            check(cap_data[(r0 + s) % 64] === exp_data(s), "R2 write data",
                  64'(cap_data[(r0 + s) % 64]), 64'(exp_data(s)));
            check(cap_addr[(r0 + s) % 64] === exp_addr(s, bm, b), bm ? "R4 byte-mode address" : "R3 word-mode address",
                  64'(cap_addr[(r0 + s) % 64]), 64'(exp_addr(s, bm, b)));
        end
    endtask

    int  wd_cycles = 0;
    bit  wd_fired  = 1'b0;

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 20000 && !wd_fired) begin
            wd_fired = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd_cycles, 20000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r0, f0, b0, n;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!bus_we && !busy && !done && !timeout_err, "R1 outputs in reset",
              64'({bus_we, busy, done, timeout_err}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_we && !busy && !done && !timeout_err && bus_addr == '0 && bus_data == '0,
              "R1 outputs after reset", 64'({bus_we, busy, done, timeout_err}), 64'h0);

        // Vector loop: main pattern in both modes, done latency
        for (int v = 0; v < NV; v++) begin
            r0 = mon_rises; f0 = mon_falls; b0 = mon_bad;
            ready = 1'b0;
            pulse_start(VECS[v].bm, VECS[v].base);
            check(busy === 1'b1, "R6 busy after start", 64'(busy), 64'h1);
            base_addr = ~VECS[v].base;
            byte_mode = ~VECS[v].bm;
            wait_falls(f0 + 6);
            @(negedge clk);
            for (int d = 0; d < int'(VECS[v].dly); d++) @(negedge clk);
            check(busy && !done && !timeout_err, "R7 still waiting before ready",
                  64'({busy, done, timeout_err}), 64'h4);
            ready = 1'b1;
            @(negedge clk);
            check(done && !busy && !timeout_err, "R7 done one edge after ready",
                  64'({busy, done, timeout_err}), 64'h2);
            ready = 1'b0;
            @(negedge clk);
            check(!done, "R7 done is a single pulse", 64'(done), 64'h0);
            check(mon_rises - r0 == 6, "R2 six writes", 64'(mon_rises - r0), 64'd6);
            check(mon_bad == b0, "R5 setup/strobe/hold timing", 64'(mon_bad - b0), 64'h0);
            check_writes(r0, VECS[v].bm, VECS[v].base);
        end

        // R9: start while busy ignored
        r0 = mon_rises; f0 = mon_falls;
        pulse_start(1'b1, 24'h010000);
        while (mon_rises < r0 + 2) @(negedge clk);
        pulse_start(1'b0, 24'h777000);
        wait_falls(f0 + 6);
        @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        check(done === 1'b1, "R9 run completes normally", 64'(done), 64'h1);
        repeat (10) @(negedge clk);
        check(mon_rises - r0 == 6 && !busy, "R9 no extra run after ignored start",
              64'(mon_rises - r0), 64'd6);
        check_writes(r0, 1'b1, 24'h010000);

        // R8: timeout
        ready = 1'b0;
        pulse_start(1'b0, 24'h000100);
        n = 1;
        while (!timeout_err && n < 500) begin
            check(!done, "R8 no done during timeout run", 64'(done), 64'h0);
            @(negedge clk);
            n++;
        end
        check(n == 6 * (P + 2) + TO + 1, "R8 timeout edge count", 64'(n), 64'(6 * (P + 2) + TO + 1));
        check(timeout_err && !busy && !done, "R8 timeout ends run", 64'({timeout_err, busy, done}), 64'h4);
        @(negedge clk);
        check(!timeout_err, "R8 timeout is a single pulse", 64'(timeout_err), 64'h0);

        // R10: only reset stops a run
        r0 = mon_rises;
        pulse_start(1'b1, 24'h200000);
        while (mon_rises < r0 + 3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!bus_we && !busy, "R10 reset drops write-enable and busy", 64'({bus_we, busy}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(mon_rises == r0 + 3 && !busy, "R10 no writes after reset", 64'(mon_rises - r0), 64'd3);
        check(!done && !timeout_err, "R1 flags clear after reset", 64'({done, timeout_err}), 64'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule